// File: doc/BRIEF.md
# Two-Wire Debug Register Read Slave

This block is the target end of a two-wire synchronous debug link. The host drives a debug clock and shares one data line with the slave. The slave watches for a start condition and then takes in an address byte. That byte carries a register address and a direction flag. When the flag asks for a read, the slave returns bytes from an attached register file. It can return a single byte, or keep returning bytes for as long as the host keeps clocking.

Every byte on the line takes nine debug clocks: eight data bits, then one separator bit that the host drives. In a block read, the slave moves to the next register after each byte. The address stops climbing at the last location of the read-only range, so later bytes repeat that register. The host can end the transfer with the separator bit, or cut it short with a new start condition.

Both line inputs are brought into the system clock domain through a two-stage synchronizer before any edge is detected. All framing runs on the system clock. The register file is reached through a registered address and a one-cycle read strobe. The data line is driven through a separate output value and output enable.

Top module: `dbg_rd_slave`

## Requirements
- R1: A fall of the data line while the debug clock is high is a start condition. From any state, it clears the bit count and waits for a new address byte.
- R2: The address byte is sent most significant bit first. It is seven address bits followed by a direction bit, where 1 selects a read. The ninth clock of that byte is a separator, and its value is ignored.
- R3: Each read byte is driven most significant bit first and takes nine debug clocks. Each bit is put on the line after a falling debug clock edge, ready for the host to sample on the next rising edge.
- R4: The slave enables its data output only for the eight data bits of a read byte. The output is released during every separator bit and at all other times.
- R5: The register address is loaded from the address byte. There is exactly one read strobe per data byte. A separator value of 0 continues the block with the next register address.
- R6: The register address does not advance past 1Fh. A block read that reaches 1Fh, or starts at or above it, repeats the same register for every later byte.
- R7: A separator value of 1 ends the read. Further debug clocks cause no driving and no read strobes until the next start condition.
- R8: A direction bit of 0 causes no driving and no read strobes until the next start condition.
- R9: A start condition issued in the middle of an address byte or between the bytes of a block read abandons the old transfer. The new address is then served correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_clk_i | input | 1 | Debug clock from the host, asynchronous |
| dbg_dat_i | input | 1 | Resolved level of the shared data line |
| dbg_dat_o | output | 1 | Value the slave puts on the data line |
| dbg_dat_oe_o | output | 1 | Output enable for the data line driver |
| reg_addr_o | output | 7 | Register file read address |
| reg_rd_o | output | 1 | One-cycle read strobe; data is taken in the same cycle |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |

## Verification
The assertions assume the host changes the data line only while the debug clock is low, except when it deliberately makes a start condition. They also assume the host never drives a start while the slave holds the line. Each debug clock phase must span enough system clocks for the synchronizer and the output register to settle. The bench host model holds each debug clock phase for eight system clocks and changes its data only in the low phase. It issues start conditions only after a rising edge at which the slave has released the line.

// File: rtl/dbg_rd_pkg.sv
// Shared types for the two-wire debug read slave.
package dbg_rd_pkg;
    // Framing state of the slave.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_READ = 2'd2
    } dbg_state_e;
endpackage

// File: rtl/dbg_line_sync.sv
// Synchronizes the debug clock and data line into the system clock domain
// and reports debug clock edges and start conditions.
// Assumes: both inputs idle high; STAGES >= 2.
module dbg_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    input  logic ddat_i,
    output logic dclk_rise_o,
    output logic dclk_fall_o,
    output logic start_o,
    output logic ddat_s_o
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_d;
    logic              dat_d;
    logic              clk_s;
    logic              dat_s;

    assign clk_s = clk_pipe[STAGES-1];
    assign dat_s = dat_pipe[STAGES-1];

    // Synchronizer chains, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '1;
            dat_pipe <= '1;
        end else begin
            clk_pipe <= {clk_pipe[STAGES-2:0], dclk_i};
            dat_pipe <= {dat_pipe[STAGES-2:0], ddat_i};
        end
    end

    // One-cycle delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b1;
            dat_d <= 1'b1;
        end else begin
            clk_d <= clk_s;
            dat_d <= dat_s;
        end
    end

    assign dclk_rise_o = clk_s & ~clk_d;
    assign dclk_fall_o = ~clk_s & clk_d;
    assign start_o     = clk_s & clk_d & dat_d & ~dat_s;
    assign ddat_s_o    = dat_s;
endmodule

// File: rtl/dbg_frame_ctrl.sv
// Bit and byte framing for the debug read slave: captures the address byte,
// counts nine clocks per byte, sequences the block read address with
// saturation, and issues load/shift/release controls to the transmitter.
// Assumes: edge and start pulses are single-cycle and never coincide.
module dbg_frame_ctrl
    import dbg_rd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RO_LAST = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              dat_i,
    output dbg_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              release_o
);
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] SEP_IDX = CNT_W'(DATA_W);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(RO_LAST);

    dbg_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W:0]   addr_sh_q;
    logic [ADDR_W-1:0] addr_q;

    // Framing state, bit counter, address shift-in and block address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            addr_sh_q <= '0;
            addr_q    <= '0;
        end else if (start_i) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
        end else if (rise_i) begin
            unique case (state_q)
                ST_ADDR: begin
                    if (cnt_q == SEP_IDX) begin
                        cnt_q   <= '0;
                        addr_q  <= addr_sh_q[ADDR_W:1];
                        state_q <= addr_sh_q[0] ? ST_READ : ST_IDLE;
                    end else begin
                        addr_sh_q <= {addr_sh_q[ADDR_W-1:0], dat_i};
                        cnt_q     <= cnt_q + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt_q == SEP_IDX) begin
                        cnt_q <= '0;
                        if (dat_i) begin
                            state_q <= ST_IDLE;
                        end else if (addr_q < TOP_ADDR) begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Transmitter controls decoded on the falling debug clock edge.
    always_comb begin
        load_o    = 1'b0;
        shift_o   = 1'b0;
        release_o = start_i;
        if (fall_i && state_q == ST_READ) begin
            if (cnt_q == '0)          load_o    = 1'b1;
            else if (cnt_q == SEP_IDX) release_o = 1'b1;
            else                       shift_o   = 1'b1;
        end
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;

    // R2
    frame_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SEP_IDX);

    // R6
    addr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && addr_q >= TOP_ADDR) |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/dbg_tx_shift.sv
// Output shifter for read data: loads a register byte, presents it most
// significant bit first one bit per falling debug clock edge, and owns the
// data line output enable.
// Assumes: load, shift and release are mutually exclusive; DATA_W >= 3.
module dbg_tx_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              release_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              dat_o,
    output logic              oe_o
);
    logic [DATA_W-2:0] sh_q;
    logic              dat_q;
    logic              oe_q;

    // Byte load, bit shifting and output enable control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            dat_q <= 1'b1;
            oe_q  <= 1'b0;
        end else if (load_i) begin
            dat_q <= rdata_i[DATA_W-1];
            sh_q  <= rdata_i[DATA_W-2:0];
            oe_q  <= 1'b1;
        end else if (shift_i) begin
            dat_q <= sh_q[DATA_W-2];
            sh_q  <= {sh_q[DATA_W-3:0], 1'b0};
        end else if (release_i) begin
            oe_q  <= 1'b0;
        end
    end

    assign dat_o = dat_q;
    assign oe_o  = oe_q;
endmodule

// File: rtl/dbg_rd_slave.sv
// Top level of the two-wire debug register read slave: synchronizer,
// framing controller and output shifter.
// Assumes: the host changes data only while the debug clock is low, apart
// from start conditions, and holds each clock phase for several clk cycles.
module dbg_rd_slave
    import dbg_rd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned RO_LAST     = 31,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_clk_i,
    input  logic              dbg_dat_i,
    output logic              dbg_dat_o,
    output logic              dbg_dat_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    logic       rise;
    logic       fall;
    logic       start;
    logic       dat_s;
    logic       load;
    logic       shift;
    logic       release_l;
    dbg_state_e state;

    dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .dclk_i      (dbg_clk_i),
        .ddat_i      (dbg_dat_i),
        .dclk_rise_o (rise),
        .dclk_fall_o (fall),
        .start_o     (start),
        .ddat_s_o    (dat_s)
    );

    dbg_frame_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RO_LAST (RO_LAST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .fall_i    (fall),
        .start_i   (start),
        .dat_i     (dat_s),
        .state_o   (state),
        .addr_o    (reg_addr_o),
        .load_o    (load),
        .shift_o   (shift),
        .release_o (release_l)
    );

    dbg_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .shift_i   (shift),
        .release_i (release_l),
        .rdata_i   (reg_rdata_i),
        .dat_o     (dbg_dat_o),
        .oe_o      (dbg_dat_oe_o)
    );

    assign reg_rd_o = load;

    // R1
    start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_ADDR));

    // R3
    load_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |-> !dbg_dat_oe_o);

    // R4
    drive_only_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_dat_oe_o |-> (state == ST_READ));
endmodule

// File: tb/dbg_rd_slave_bench.sv
module dbg_rd_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dclk = 1'b1;
    logic       hdat = 1'b1;
    logic       dat_o;
    logic       dat_oe;
    logic [6:0] reg_addr;
    logic       reg_rd;
    logic [7:0] reg_rdata;
    logic       line;
    int         checks = 0;
    int         errors = 0;
    int         rd_pulses = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] regval(input logic [6:0] a);
        return {a, 1'b0} ^ 8'h5A;
    endfunction

    assign reg_rdata = regval(reg_addr);
    assign line      = dat_oe ? dat_o : hdat;

    dbg_rd_slave u_dbg_rd_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_clk_i    (dclk),
        .dbg_dat_i    (line),
        .dbg_dat_o    (dat_o),
        .dbg_dat_oe_o (dat_oe),
        .reg_addr_o   (reg_addr),
        .reg_rd_o     (reg_rd),
        .reg_rdata_i  (reg_rdata)
    );

    always @(posedge clk) if (rst_n && reg_rd) rd_pulses <= rd_pulses + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One debug clock: low phase with host data, then high phase.
    task automatic host_bit(input logic b, output logic smp, output logic smp_oe);
        dclk = 1'b0;
        hdat = b;
        wait_n(8);
        smp    = line;
        smp_oe = dat_oe;
        dclk = 1'b1;
        wait_n(8);
    endtask

    task automatic start_cond();
        dclk = 1'b1;
        hdat = 1'b1;
        wait_n(8);
        hdat = 1'b0;
        wait_n(8);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw);
        logic s, o;
        start_cond();
        for (int i = 6; i >= 0; i--) host_bit(a[i], s, o);
        host_bit(rw, s, o);
        host_bit(1'b0, s, o);
    endtask

    // Read one byte; oe_ok reports driving during data and release at separator.
    task automatic get_byte(input logic sep, output logic [7:0] b, output bit oe_ok);
        logic s, o;
        oe_ok = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            host_bit(1'b1, s, o);
            b = {b[6:0], s};
            if (!o) oe_ok = 1'b0;
        end
        host_bit(sep, s, o);
        if (o) oe_ok = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        check(dat_oe == 1'b0, "R4 reset oe", dat_oe, 0);
        check(reg_addr == 7'h00, "R5 reset addr", reg_addr, 0);
        check(rd_pulses == 0, "R5 reset strobe", rd_pulses, 0);
    endtask

    task automatic t_single();
        logic [7:0] b;
        bit ok;
        int p0;
        send_addr(7'h05, 1'b1);
        p0 = rd_pulses;
        get_byte(1'b1, b, ok);
        check(b == regval(7'h05), "R2 R3 single read data", b, regval(7'h05));
        check(ok, "R4 drive window", ok, 1);
        check(rd_pulses - p0 == 1, "R5 one strobe per byte", rd_pulses - p0, 1);
    endtask

    task automatic t_block_sat();
        logic [7:0] b;
        bit ok;
        send_addr(7'h1C, 1'b1);
        for (int i = 0; i < 6; i++) begin
            int e = (i < 3) ? (8'h1C + i) : 8'h1F;
            get_byte(i == 5, b, ok);
            check(b == regval(7'(e)), "R5 R6 block byte", b, regval(7'(e)));
            check(ok, "R4 block drive window", ok, 1);
        end
    endtask

    task automatic t_above_top();
        logic [7:0] b;
        bit ok;
        send_addr(7'h40, 1'b1);
        get_byte(1'b0, b, ok);
        check(b == regval(7'h40), "R6 high addr byte0", b, regval(7'h40));
        get_byte(1'b1, b, ok);
        check(b == regval(7'h40), "R6 high addr held", b, regval(7'h40));
    endtask

    task automatic t_end_by_sep();
        logic [7:0] b;
        bit ok;
        logic s, o;
        int p0;
        int drv = 0;
        send_addr(7'h03, 1'b1);
        get_byte(1'b1, b, ok);
        p0 = rd_pulses;
        for (int i = 0; i < 18; i++) begin
            host_bit(1'b1, s, o);
            if (o) drv++;
        end
        check(drv == 0, "R7 no drive after end", drv, 0);
        check(rd_pulses == p0, "R7 no strobe after end", rd_pulses - p0, 0);
    endtask

    task automatic t_write_sel();
        logic s, o;
        int p0;
        int drv = 0;
        send_addr(7'h05, 1'b0);
        p0 = rd_pulses;
        for (int i = 0; i < 18; i++) begin
            host_bit(i[0], s, o);
            if (o) drv++;
        end
        check(drv == 0, "R8 write no drive", drv, 0);
        check(rd_pulses == p0, "R8 write no strobe", rd_pulses - p0, 0);
    endtask

    task automatic t_restart_addr();
        logic [7:0] b;
        bit ok;
        logic s, o;
        start_cond();
        host_bit(1'b1, s, o);
        host_bit(1'b0, s, o);
        host_bit(1'b1, s, o);
        send_addr(7'h0A, 1'b1);
        get_byte(1'b1, b, ok);
        check(b == regval(7'h0A), "R1 R9 restart mid-address", b, regval(7'h0A));
    endtask

    task automatic t_restart_block();
        logic [7:0] b;
        bit ok;
        send_addr(7'h02, 1'b1);
        get_byte(1'b0, b, ok);
        check(b == regval(7'h02), "R9 first block byte", b, regval(7'h02));
        send_addr(7'h10, 1'b1);
        check(reg_addr == 7'h10, "R9 new address loaded", reg_addr, 7'h10);
        get_byte(1'b1, b, ok);
        check(b == regval(7'h10), "R9 byte after restart", b, regval(7'h10));
        check(ok, "R4 drive window after restart", ok, 1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_block_sat();
        t_above_top();
        t_end_by_sep();
        t_write_sel();
        t_restart_addr();
        t_restart_block();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule